// File: doc/BRIEF.md
# Dual-Modulus Feedback Divider

This block divides a fast input clock by a programmable integer N = 4·B + A. It is the digital half of a frequency-synthesis loop: its output stands in for the divided clock that a phase detector compares against a reference. The division is built as a pulse-swallow structure. A prescaler stage counts input cycles modulo 4 or modulo 5. A main counter counts prescaler cycles up to B. The prescaler runs at modulus 5 while the main count is still below A, which swallows one extra input cycle per step, and at modulus 4 for the rest of the period.

The settings A (0 to 3) and B (3 to 63) come in on plain input ports. They take effect only when a period ends, so a change never shortens or stretches the period already running. A combination the structure cannot realise raises a flag at once and is never loaded: B below 3 or above 63, A above 3, or A greater than B. In that case the divider keeps the ratio it already has.

Top module: `fbdiv_top`

## Requirements
- R1: With a legal setting (A, B) in effect, rising `div_pulse` edges are exactly 4·B + A input clock cycles apart.
- R2: With A = 0, the pulse spacing is exactly 4·B, because every prescaler cycle uses modulus 4.
- R3: `div_pulse` is high for exactly one input clock cycle, and that cycle is the last cycle of each N-cycle period.
- R4: `cfg_bad` is high in the same cycle, combinationally, exactly when the applied setting is illegal: B < 3, B > 63, A > 3, or A > B. It is low for every other setting.
- R5: `a_set` and `b_set` are sampled only on the clock edge that ends a period. A change made in the middle of a period leaves that period's length unchanged, and the new ratio applies from the next period.
- R6: An illegal setting present at the end of a period is ignored. The previous ratio stays in effect for the following periods.
- R7: While `rst` (synchronous, active high) is asserted, `div_pulse` is low. After release the divider runs with A = 0 and B = 3, so the first pulse falls in the 12th cycle counted from the first cycle after the reset edge. Any legal setting applied is loaded at the end of that first period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock being divided |
| rst | input | 1 | Synchronous reset, active high |
| a_set | input | 2 | Swallow count A, legal range 0 to 3 |
| b_set | input | 6 | Main count B, legal range 3 to 63 |
| div_pulse | output | 1 | One-cycle pulse on the last cycle of each period |
| cfg_bad | output | 1 | High while the applied A/B pair is illegal |

## Verification
The embedded assertions check several things on every cycle. The output pulse never lasts two cycles. The main count stays below the loaded B. The loaded pair is always legal. The loaded values stay frozen except on a period-ending edge, and they do not change on such an edge when the applied pair is flagged. The bench's scenarios are needed for what only shows over whole periods. That includes the measured spacing for every legal (A, B) pair, the first period after reset, a setting changed in the middle of a period, and an illegal setting being held off across several periods. A behavioural cycle model compares the pulse and the flag on every clock.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;

    // Prescaler modulus selection: NARROW divides by P, WIDE by P+1
    typedef enum logic {
        MOD_NARROW = 1'b0,
        MOD_WIDE   = 1'b1
    } mod_sel_e;

    localparam int DEF_PRE_MOD = 4;
    localparam int DEF_A_W     = 2;
    localparam int DEF_B_W     = 6;
    localparam int DEF_A_MAX   = 3;
    localparam int DEF_B_MIN   = 3;
    localparam int DEF_B_MAX   = 63;

endpackage

// File: rtl/fbdiv_prescaler.sv
module fbdiv_prescaler
    import fbdiv_pkg::*;
#(
    parameter int PRE_MOD = DEF_PRE_MOD
) (
    input  logic     clk,
    input  logic     rst,
    input  mod_sel_e mod_sel,
    output logic     pre_wrap
);
    localparam int CW = $clog2(PRE_MOD + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } pre_state_t;

    pre_state_t    st_d, st_q;
    logic [CW-1:0] last_val;

    always_comb begin
        st_d     = st_q;
        last_val = (mod_sel == MOD_WIDE) ? CW'(PRE_MOD) : CW'(PRE_MOD - 1);
        pre_wrap = (st_q.cnt == last_val);
        if (rst) begin
            st_d.cnt = '0;
        end else if (pre_wrap) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // the prescaler count never passes the wide modulus
    AST_PRE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        int'(st_q.cnt) <= PRE_MOD); // R1

endmodule

// File: rtl/fbdiv_range_chk.sv
module fbdiv_range_chk
    import fbdiv_pkg::*;
#(
    parameter int A_W   = DEF_A_W,
    parameter int B_W   = DEF_B_W,
    parameter int A_MAX = DEF_A_MAX,
    parameter int B_MIN = DEF_B_MIN,
    parameter int B_MAX = DEF_B_MAX
) (
    input  logic [A_W-1:0] a_in,
    input  logic [B_W-1:0] b_in,
    output logic           set_ok
);
    logic b_lo_ok, b_hi_ok, a_hi_ok, a_le_b;

    always_comb begin
        b_lo_ok = int'(b_in) >= B_MIN;
        b_hi_ok = int'(b_in) <= B_MAX;
        a_hi_ok = int'(a_in) <= A_MAX;
        a_le_b  = int'(a_in) <= int'(b_in);
        set_ok  = b_lo_ok && b_hi_ok && a_hi_ok && a_le_b;
    end

endmodule

// File: rtl/fbdiv_cycle_ctl.sv
module fbdiv_cycle_ctl
    import fbdiv_pkg::*;
#(
    parameter int A_W   = DEF_A_W,
    parameter int B_W   = DEF_B_W,
    parameter int B_MIN = DEF_B_MIN
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           pre_wrap,
    input  logic           load_ok,
    input  logic [A_W-1:0] a_in,
    input  logic [B_W-1:0] b_in,
    output mod_sel_e       mod_sel,
    output logic           period_end
);
    typedef struct packed {
        logic [B_W-1:0] sc;
        logic [A_W-1:0] a_sh;
        logic [B_W-1:0] b_sh;
    } ctl_state_t;

    ctl_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        mod_sel    = (st_q.sc < B_W'(st_q.a_sh)) ? MOD_WIDE : MOD_NARROW;
        period_end = pre_wrap && (st_q.sc == st_q.b_sh - B_W'(1));
        if (rst) begin
            st_d.sc   = '0;
            st_d.a_sh = '0;
            st_d.b_sh = B_W'(B_MIN);
        end else if (period_end) begin
            st_d.sc = '0;
            if (load_ok) begin
                st_d.a_sh = a_in;
                st_d.b_sh = b_in;
            end
        end else if (pre_wrap) begin
            st_d.sc = st_q.sc + B_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    AST_SC_BELOW_B: assert property (@(posedge clk) disable iff (rst)
        st_q.sc < st_q.b_sh); // R1

    AST_SHADOW_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (int'(st_q.b_sh) >= B_MIN) && (int'(st_q.a_sh) <= int'(st_q.b_sh))); // R4

    AST_HOLD_MIDPERIOD: assert property (@(posedge clk) disable iff (rst)
        !period_end |=> ($stable(st_q.a_sh) && $stable(st_q.b_sh))); // R5

    AST_REJECT_BAD: assert property (@(posedge clk) disable iff (rst)
        (period_end && !load_ok) |=> ($stable(st_q.a_sh) && $stable(st_q.b_sh))); // R6

endmodule

// File: rtl/fbdiv_top.sv
module fbdiv_top
    import fbdiv_pkg::*;
#(
    parameter int PRE_MOD = DEF_PRE_MOD,
    parameter int A_W     = DEF_A_W,
    parameter int B_W     = DEF_B_W,
    parameter int A_MAX   = DEF_A_MAX,
    parameter int B_MIN   = DEF_B_MIN,
    parameter int B_MAX   = DEF_B_MAX
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [A_W-1:0] a_set,
    input  logic [B_W-1:0] b_set,
    output logic           div_pulse,
    output logic           cfg_bad
);
    mod_sel_e mod_sel;
    logic     pre_wrap;
    logic     set_ok;

    fbdiv_range_chk #(
        .A_W   (A_W),
        .B_W   (B_W),
        .A_MAX (A_MAX),
        .B_MIN (B_MIN),
        .B_MAX (B_MAX)
    ) u_range (
        .a_in   (a_set),
        .b_in   (b_set),
        .set_ok (set_ok)
    );

    fbdiv_prescaler #(
        .PRE_MOD (PRE_MOD)
    ) u_pre (
        .clk      (clk),
        .rst      (rst),
        .mod_sel  (mod_sel),
        .pre_wrap (pre_wrap)
    );

    fbdiv_cycle_ctl #(
        .A_W   (A_W),
        .B_W   (B_W),
        .B_MIN (B_MIN)
    ) u_ctl (
        .clk        (clk),
        .rst        (rst),
        .pre_wrap   (pre_wrap),
        .load_ok    (set_ok),
        .a_in       (a_set),
        .b_in       (b_set),
        .mod_sel    (mod_sel),
        .period_end (div_pulse)
    );

    always_comb begin
        cfg_bad = !set_ok;
    end

    // a period is at least P*B_MIN cycles, so a pulse never repeats next cycle
    AST_PULSE_ONE_WIDE: assert property (@(posedge clk) disable iff (rst)
        div_pulse |=> !div_pulse); // R3

endmodule

// File: tb/tb_fbdiv_top.sv
module tb_fbdiv_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] a_set = 2'd0;
    logic [5:0] b_set = 6'd3;
    logic       div_pulse;
    logic       cfg_bad;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // behavioural reference state
    int m_cnt = 0;
    int m_a   = 0;
    int m_b   = 3;

    fbdiv_top dut (
        .clk       (clk),
        .rst       (rst),
        .a_set     (a_set),
        .b_set     (b_set),
        .div_pulse (div_pulse),
        .cfg_bad   (cfg_bad)
    );

    always #5 clk = ~clk;

    function automatic bit legal(int a, int b);
        return (b >= 3) && (b <= 63) && (a <= 3) && (a <= b);
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic drive(int a, int b);
        @(posedge clk);
        #2;
        a_set = 2'(a);
        b_set = 6'(b);
    endtask

    task automatic gap(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!div_pulse);
    endtask

    // cycle model, compared on every clock away from the active edge
    always @(negedge clk) begin
        int n_cur;
        if (!done) begin
            n_cur = 4 * m_b + m_a;
            chk("R3 pulse", int'(div_pulse), (!rst && m_cnt == n_cur - 1) ? 1 : 0);
            chk("R4 flag", int'(cfg_bad), legal(int'(a_set), int'(b_set)) ? 0 : 1);
            if (rst) begin
                m_cnt = 0; m_a = 0; m_b = 3;
            end else if (m_cnt == n_cur - 1) begin
                m_cnt = 0;
                if (legal(int'(a_set), int'(b_set))) begin
                    m_a = int'(a_set); m_b = int'(b_set);
                end
            end else begin
                m_cnt++;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int g;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R7 reset low", int'(div_pulse), 0);
        @(posedge clk);
        #2;
        rst = 1'b0;
        gap(g);
        chk("R7 first period", g, 12);

        // R1 / R2: every legal pair
        for (int b = 3; b <= 63; b++) begin
            for (int a = 0; a <= 3; a++) begin
                drive(a, b);
                gap(g);
                gap(g);
                chk(a == 0 ? "R2 spacing" : "R1 spacing", g, 4 * b + a);
            end
        end

        // R5: change in the middle of a period
        drive(0, 10);
        gap(g);
        gap(g);
        chk("R2 spacing", g, 40);
        g = 0;
        repeat (5) begin
            @(negedge clk);
            g++;
        end
        drive(3, 20);
        do begin
            @(negedge clk);
            g++;
        end while (!div_pulse);
        chk("R5 current period kept", g, 40);
        gap(g);
        chk("R5 new ratio next", g, 83);

        // R4 / R6: illegal settings rejected
        drive(1, 10);
        gap(g);
        gap(g);
        chk("R1 spacing", g, 41);
        drive(0, 2);
        @(negedge clk);
        chk("R4 b below min", int'(cfg_bad), 1);
        gap(g);
        gap(g);
        chk("R6 ratio kept", g, 41);
        drive(3, 1);
        @(negedge clk);
        chk("R4 a above b", int'(cfg_bad), 1);
        gap(g);
        gap(g);
        chk("R6 ratio kept", g, 41);
        drive(3, 3);
        @(negedge clk);
        chk("R4 a equals b legal", int'(cfg_bad), 0);
        gap(g);
        gap(g);
        chk("R1 spacing", g, 15);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule